// File: doc/BRIEF.md
# DRAM ECC Error Status and Capture Register Block

This block sits next to the ECC checker of a DRAM controller and turns its per-access error pulses into software-visible state. A one-cycle pulse on `err_sbe` (correctable) or `err_mbe` (uncorrectable) comes with the failing address, the 64 data bits and the check bits. The block keeps a two-flag detect register whose bits are cleared by writing ones. It snapshots the failing access into capture registers. It counts correctable errors against a programmable threshold, so that an interrupt can be rate-limited, and it drives an interrupt line through per-type enable bits.

A per-type disable register suppresses detection entirely. The block also holds injection masks for the upper and lower data words and for the check bits. While injection is enabled, these masks are XORed into the write path toward the DRAM. Software reaches every register through a simple 32-bit write port, addressed by word index, with a combinational read mux.

The capture logic is a two-state machine. In `CAP_ARMED` (the reset state), the transition `ARM_TO_HELD` is taken when any detect flag is being set, and the capture registers load in that same edge. In `CAP_HELD`, the capture registers hold. The transition `HELD_TO_ARMED` is taken once the detect register reads all zero. If a new flagged error arrives in that cycle, the block captures it and stays in `CAP_HELD` (transition `HELD_RECAPTURE`).

Top module: `ecc_err_regs`

Register word indices:
- 0: detect. Bit 0 is the correctable flag and bit 1 the uncorrectable flag; writing 1 to a bit clears it.
- 1: disable. Bit 0 masks correctable detection, bit 1 masks uncorrectable detection.
- 2: interrupt enable. Bit 0 is for correctable errors, bit 1 for uncorrectable errors.
- 3: correctable management. Bits 23:16 hold the threshold (read/write); bits 7:0 hold the current count (read-only).
- 4: captured upper data word.
- 5: captured lower data word.
- 6: captured check bits.
- 7: captured address bits 31:0.
- 8: captured address bits above 31, zero-extended.
- 9: upper data injection mask.
- 10: lower data injection mask.
- 11: injection control. Bits 15:0 hold the check-bit mask; bit 16 enables injection.

## Requirements
- R1: After reset every register index 0 to 11 reads 0 and `irq` is low.
- R2: Indices 9 and 10 read back the full 32 bits last written. Index 11 reads back bits 16:0 of the last write, with bits 31:17 reading 0.
- R3: When bit 16 of index 11 is 1, `wr_data_out` equals `wr_data_in` XOR {index 9, index 10} and `wr_check_out` equals `wr_check_in` XOR index 11 bits 15:0. When bit 16 is 0, both outputs equal their inputs.
- R4: An `err_mbe` pulse while disable bit 1 is 0 sets detect bit 1 at the next clock edge.
- R5: Each enabled `err_sbe` pulse adds one to the count. When the incremented count reaches the threshold (index 3 bits 23:16), detect bit 0 is set and the count returns to 0. A threshold of 0 acts as 1. Writing index 3 clears the count.
- R6: While disable bit 0 is 1, `err_sbe` changes neither the count nor detect bit 0. While disable bit 1 is 1, `err_mbe` does not set detect bit 1.
- R7: Writing 1 to a detect bit clears it and writing 0 leaves it unchanged. If a set and a clear of the same bit happen in one cycle, the set wins.
- R8: The error that sets a detect flag while the capture machine is armed loads its upper data, lower data, check bits, address bits 31:0 and upper address bits into indices 4 to 8.
- R9: Once captured, indices 4 to 8 keep their values through later errors until the detect register reads all zero. The next flagged error after that is captured again.
- R10: With `bus32` high, all 16 captured check bits are kept. With `bus32` low, only bits 7:0 are kept and bits 15:8 read 0.
- R11: `irq` is high exactly when some detect bit is set together with its interrupt enable bit.
- R12: The capture machine stays in `CAP_HELD` while the detect register is nonzero and returns to `CAP_ARMED` only through a cycle in which it reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| err_sbe | input | 1 | Correctable error pulse |
| err_mbe | input | 1 | Uncorrectable error pulse |
| err_addr | input | ADDR_W (40) | Failing address |
| err_data | input | 64 | Failing data, upper word in bits 63:32 |
| err_check | input | 16 | Failing check bits |
| bus32 | input | 1 | 1 = 32-bit bus mode (16-bit check field) |
| wr_data_in | input | 64 | Write data toward DRAM |
| wr_check_in | input | 16 | Write check bits toward DRAM |
| wr_data_out | output | 64 | Write data after injection |
| wr_check_out | output | 16 | Check bits after injection |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that error pulses are single-cycle and come from the checker independently of register writes. They also assume that a write to the management register, which clears the count, is never issued in the same cycle as a correctable pulse. The stimulus drives every pulse and every write as a separate one-cycle event placed between clock edges. The only deliberate overlap is a detect clear coinciding with an uncorrectable pulse, which exercises the set-wins rule. Random thresholds stay between 1 and 5 so that many threshold crossings occur within a short run.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;
    localparam int REG_AW  = 4;
    localparam int NTYPES  = 2;
    localparam int SBE_IDX = 0;
    localparam int MBE_IDX = 1;

    typedef enum logic [REG_AW-1:0] {
        RA_DETECT  = 4'd0,
        RA_DISABLE = 4'd1,
        RA_IRQEN   = 4'd2,
        RA_SBEMGT  = 4'd3,
        RA_CAP_DHI = 4'd4,
        RA_CAP_DLO = 4'd5,
        RA_CAP_CHK = 4'd6,
        RA_CAP_ALO = 4'd7,
        RA_CAP_AHI = 4'd8,
        RA_INJ_HI  = 4'd9,
        RA_INJ_LO  = 4'd10,
        RA_INJ_CTL = 4'd11
    } reg_sel_e;

    typedef enum logic {
        CAP_ARMED = 1'b0,
        CAP_HELD  = 1'b1
    } cap_state_e;
endpackage

// File: rtl/ecc_sbe_counter.sv
module ecc_sbe_counter #(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             clear,
    input  logic [THR_W-1:0] thr,
    output logic [THR_W-1:0] cnt,
    output logic             reach
);
    logic [THR_W:0] inc;

    assign inc   = {1'b0, cnt} + 1'b1;
    // a zero threshold compares as already reached, i.e. behaves as one
    assign reach = hit && (inc >= {1'b0, thr});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (hit)
            cnt <= reach ? '0 : inc[THR_W-1:0];
    end
endmodule

// File: rtl/ecc_capture_fsm.sv
module ecc_capture_fsm
    import ecc_err_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int DATA_W = 64,
    parameter int CHK_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_set,
    input  logic              det_any,
    input  logic              bus32,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic [DATA_W-1:0] err_data,
    input  logic [CHK_W-1:0]  err_check,
    output cap_state_e        state,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data,
    output logic [CHK_W-1:0]  cap_check
);
    localparam int HALF = CHK_W / 2;

    cap_state_e       nxt;
    logic             take;
    logic [CHK_W-1:0] chk_sel;

    assign chk_sel = bus32 ? err_check
                           : {{(CHK_W-HALF){1'b0}}, err_check[HALF-1:0]};
    assign take = flag_set && (state == CAP_ARMED || !det_any);

    always_comb begin
        nxt = state;
        unique case (state)
            CAP_ARMED: if (flag_set) nxt = CAP_HELD;                 // ARM_TO_HELD
            CAP_HELD:  if (!det_any && !flag_set) nxt = CAP_ARMED;   // HELD_TO_ARMED
            default:   nxt = CAP_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CAP_ARMED;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_addr  <= '0;
            cap_data  <= '0;
            cap_check <= '0;
        end else if (take) begin
            cap_addr  <= err_addr;
            cap_data  <= err_data;
            cap_check <= chk_sel;
        end
    end
endmodule

// File: rtl/ecc_inject.sv
module ecc_inject #(
    parameter int DATA_W = 64,
    parameter int CHK_W  = 16
) (
    input  logic              en,
    input  logic [DATA_W-1:0] mask_data,
    input  logic [CHK_W-1:0]  mask_check,
    input  logic [DATA_W-1:0] data_in,
    input  logic [CHK_W-1:0]  check_in,
    output logic [DATA_W-1:0] data_out,
    output logic [CHK_W-1:0]  check_out
);
    assign data_out  = data_in  ^ (mask_data  & {DATA_W{en}});
    assign check_out = check_in ^ (mask_check & {CHK_W{en}});
endmodule

// File: rtl/ecc_err_regs.sv
module ecc_err_regs
    import ecc_err_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int THR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              err_sbe,
    input  logic              err_mbe,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic [63:0]       err_data,
    input  logic [15:0]       err_check,
    input  logic              bus32,
    input  logic [63:0]       wr_data_in,
    input  logic [15:0]       wr_check_in,
    output logic [63:0]       wr_data_out,
    output logic [15:0]       wr_check_out,
    output logic              irq
);
    localparam int DATA_W = 64;
    localparam int CHK_W  = 16;
    localparam int WORD   = 32;
    localparam int EXT_W  = ADDR_W - WORD;
    localparam int THR_LO = 16;
    localparam int INJ_EN = CHK_W;

    logic [NTYPES-1:0] det_q, dis_q, ien_q, set_v, clr_v, raw_v;
    logic [THR_W-1:0]  thr_q, sbe_cnt;
    logic [WORD-1:0]   inj_hi_q, inj_lo_q;
    logic [CHK_W-1:0]  inj_chk_q;
    logic              inj_en_q, sbe_reach, mgt_wr;
    cap_state_e        cap_state;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;
    logic [CHK_W-1:0]  cap_check;

    assign mgt_wr = reg_wr && (reg_addr == RA_SBEMGT);
    assign clr_v  = (reg_wr && reg_addr == RA_DETECT) ? reg_wdata[NTYPES-1:0] : '0;
    assign raw_v[SBE_IDX] = err_sbe;
    assign raw_v[MBE_IDX] = err_mbe;

    ecc_sbe_counter #(.THR_W(THR_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .hit(err_sbe && !dis_q[SBE_IDX]),
        .clear(mgt_wr), .thr(thr_q), .cnt(sbe_cnt), .reach(sbe_reach)
    );

    genvar t;
    generate
        for (t = 0; t < NTYPES; t++) begin : g_type
            if (t == SBE_IDX) begin : g_thr
                assign set_v[t] = sbe_reach;
            end else begin : g_direct
                assign set_v[t] = raw_v[t] && !dis_q[t];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) det_q[t] <= 1'b0;
                else        det_q[t] <= set_v[t] | (det_q[t] & ~clr_v[t]);
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dis_q     <= '0;
            ien_q     <= '0;
            thr_q     <= '0;
            inj_hi_q  <= '0;
            inj_lo_q  <= '0;
            inj_chk_q <= '0;
            inj_en_q  <= 1'b0;
        end else if (reg_wr) begin
            case (reg_addr)
                RA_DISABLE: dis_q    <= reg_wdata[NTYPES-1:0];
                RA_IRQEN:   ien_q    <= reg_wdata[NTYPES-1:0];
                RA_SBEMGT:  thr_q    <= reg_wdata[THR_LO +: THR_W];
                RA_INJ_HI:  inj_hi_q <= reg_wdata;
                RA_INJ_LO:  inj_lo_q <= reg_wdata;
                RA_INJ_CTL: begin
                    inj_chk_q <= reg_wdata[CHK_W-1:0];
                    inj_en_q  <= reg_wdata[INJ_EN];
                end
                default: ;
            endcase
        end
    end

    ecc_capture_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHK_W(CHK_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .flag_set(|set_v), .det_any(|det_q),
        .bus32(bus32), .err_addr(err_addr), .err_data(err_data),
        .err_check(err_check), .state(cap_state), .cap_addr(cap_addr),
        .cap_data(cap_data), .cap_check(cap_check)
    );

    ecc_inject #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_inj (
        .en(inj_en_q), .mask_data({inj_hi_q, inj_lo_q}), .mask_check(inj_chk_q),
        .data_in(wr_data_in), .check_in(wr_check_in),
        .data_out(wr_data_out), .check_out(wr_check_out)
    );

    assign irq = |(det_q & ien_q);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_DETECT:  reg_rdata[NTYPES-1:0] = det_q;
            RA_DISABLE: reg_rdata[NTYPES-1:0] = dis_q;
            RA_IRQEN:   reg_rdata[NTYPES-1:0] = ien_q;
            RA_SBEMGT: begin
                reg_rdata[THR_LO +: THR_W] = thr_q;
                reg_rdata[THR_W-1:0]       = sbe_cnt;
            end
            RA_CAP_DHI: reg_rdata = cap_data[DATA_W-1:WORD];
            RA_CAP_DLO: reg_rdata = cap_data[WORD-1:0];
            RA_CAP_CHK: reg_rdata[CHK_W-1:0] = cap_check;
            RA_CAP_ALO: reg_rdata = cap_addr[WORD-1:0];
            RA_CAP_AHI: reg_rdata[EXT_W-1:0] = cap_addr[ADDR_W-1:WORD];
            RA_INJ_HI:  reg_rdata = inj_hi_q;
            RA_INJ_LO:  reg_rdata = inj_lo_q;
            RA_INJ_CTL: reg_rdata[INJ_EN:0] = {inj_en_q, inj_chk_q};
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ecc_err_regs_chk.sv
module ecc_err_regs_chk #(
    parameter int THR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [3:0]       reg_addr,
    input logic             err_sbe,
    input logic             err_mbe,
    input logic             irq,
    input logic [1:0]       dis,
    input logic [1:0]       ien,
    input logic [1:0]       det,
    input logic [THR_W-1:0] thr,
    input logic [THR_W-1:0] cnt,
    input logic             held,
    input logic [63:0]      cap_data
);
    // R4
    mbe_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_mbe && !dis[1]) |=> det[1]);

    // R11
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_mbe && !dis[1] && ien[1] && !(reg_wr && reg_addr == 4'd2)) |=> irq);

    // R5
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr != '0) |-> (cnt < thr));

    // R6
    sbe_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_sbe && dis[0] && !(reg_wr && reg_addr == 4'd3)) |=> $stable(cnt));

    // R9
    capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && det != 2'b00) |=> $stable(cap_data));

    // R12
    held_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && det != 2'b00) |=> held);
endmodule

bind ecc_err_regs ecc_err_regs_chk #(.THR_W(THR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .err_sbe(err_sbe), .err_mbe(err_mbe), .irq(irq), .dis(dis_q),
    .ien(ien_q), .det(det_q), .thr(thr_q), .cnt(sbe_cnt),
    .held(cap_state == ecc_err_pkg::CAP_HELD), .cap_data(cap_data)
);

// File: tb/ecc_err_regs_test.sv
`timescale 1ns/1ps
module ecc_err_regs_test;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        err_sbe = 1'b0, err_mbe = 1'b0, bus32 = 1'b1;
    logic [39:0] err_addr = '0;
    logic [63:0] err_data = '0, wr_data_in = '0, wr_data_out;
    logic [15:0] err_check = '0, wr_check_in = '0, wr_check_out;
    logic        irq;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ecc_err_regs uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_sbe(err_sbe),
        .err_mbe(err_mbe), .err_addr(err_addr), .err_data(err_data),
        .err_check(err_check), .bus32(bus32), .wr_data_in(wr_data_in),
        .wr_check_in(wr_check_in), .wr_data_out(wr_data_out),
        .wr_check_out(wr_check_out), .irq(irq)
    );

    function automatic logic [63:0] exp_data(bit en, logic [31:0] hi, logic [31:0] lo, logic [63:0] d);
        return en ? (d ^ {hi, lo}) : d;
    endfunction

    function automatic logic [15:0] exp_chk(bit en, logic [15:0] m, logic [15:0] c);
        return en ? (c ^ m) : c;
    endfunction

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic pulse(bit s, bit m, logic [39:0] a, logic [63:0] d, logic [15:0] c);
        err_sbe = s; err_mbe = m; err_addr = a; err_data = d; err_check = c;
        @(posedge clk); #1;
        err_sbe = 1'b0; err_mbe = 1'b0;
    endtask

    task automatic chk_cap(string req, logic [63:0] d, logic [39:0] a, logic [15:0] c);
        logic [31:0] v;
        rd(4, v); chk(req, v, d[63:32]);
        rd(5, v); chk(req, v, d[31:0]);
        rd(6, v); chk(req, v, {16'h0, c});
        rd(7, v); chk(req, v, a[31:0]);
        rd(8, v); chk(req, v, {24'h0, a[39:32]});
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, hi, lo, ctl;
        int thr, mcnt;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < 12; i++) begin
            rd(i[3:0], v); chk("R1", v, 0);
        end
        chk("R1 irq", irq, 0);

        // R2 readback
        hi = $urandom; lo = $urandom;
        wr(9, hi); wr(10, lo); wr(11, 32'hFFFF_FFFF);
        rd(9, v); chk("R2", v, hi);
        rd(10, v); chk("R2", v, lo);
        rd(11, v); chk("R2", v, 32'h0001_FFFF);

        // R3 injection, random
        for (int i = 0; i < 20; i++) begin
            hi = $urandom; lo = $urandom; ctl = $urandom & 32'h1_FFFF;
            wr(9, hi); wr(10, lo); wr(11, ctl);
            wr_data_in = {$urandom, $urandom}; wr_check_in = 16'($urandom);
            #1;
            chk("R3 data", wr_data_out, exp_data(ctl[16], hi, lo, wr_data_in));
            chk("R3 chk", {48'h0, wr_check_out}, {48'h0, exp_chk(ctl[16], ctl[15:0], wr_check_in)});
        end
        wr(11, 0);

        // R4 R8 R10 R11 first capture, 32-bit mode
        wr(2, 3);
        pulse(0, 1, 40'hA5_1234_5678, 64'h1111_2222_3333_4444, 16'hABCD);
        rd(0, v); chk("R4", v, 2);
        chk("R11 irq", irq, 1);
        chk_cap("R8", 64'h1111_2222_3333_4444, 40'hA5_1234_5678, 16'hABCD);

        // R9 R12 frozen while flag set
        pulse(0, 1, 40'h01_0000_0001, 64'hDEAD_BEEF_CAFE_F00D, 16'h1357);
        chk_cap("R9", 64'h1111_2222_3333_4444, 40'hA5_1234_5678, 16'hABCD);

        // R7 W1C
        wr(0, 1); rd(0, v); chk("R7 zero-bit", v, 2);
        wr(0, 2); rd(0, v); chk("R7 clear", v, 0);
        chk("R11 irq low", irq, 0);

        // R10 R9 rearmed capture, 64-bit mode
        bus32 = 1'b0;
        pulse(0, 1, 40'h7F_0BAD_CAFE, 64'h0123_4567_89AB_CDEF, 16'hABCD);
        chk_cap("R10", 64'h0123_4567_89AB_CDEF, 40'h7F_0BAD_CAFE, 16'h00CD);
        bus32 = 1'b1;

        // R7 set wins over simultaneous clear
        reg_wr = 1'b1; reg_addr = 0; reg_wdata = 2; err_mbe = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0; err_mbe = 1'b0;
        rd(0, v); chk("R7 set-wins", v, 2);
        wr(0, 3);

        // R6 disables
        wr(1, 3);
        pulse(1, 1, 0, 0, 0);
        rd(0, v); chk("R6 flags", v, 0);
        rd(3, v); chk("R6 count", v, 0);
        wr(1, 0);

        // R11 enable gating
        wr(2, 0);
        pulse(0, 1, 0, 0, 0);
        rd(0, v); chk("R11 flag", v, 2);
        chk("R11 gated", irq, 0);
        wr(0, 3); wr(2, 3);

        // R5 threshold 0 acts as 1
        pulse(1, 0, 0, 0, 0);
        rd(0, v); chk("R5 thr0", v, 1);
        wr(0, 3);

        // R5 threshold 3
        wr(3, 32'h0003_0000);
        pulse(1, 0, 0, 0, 0); rd(3, v); chk("R5 cnt1", v, 32'h0003_0001);
        rd(0, v); chk("R5 noflag", v, 0);
        pulse(1, 0, 0, 0, 0); rd(3, v); chk("R5 cnt2", v, 32'h0003_0002);
        pulse(1, 0, 0, 0, 0); rd(3, v); chk("R5 wrap", v, 32'h0003_0000);
        rd(0, v); chk("R5 flag", v, 1);
        chk("R11 sbe irq", irq, 1);
        wr(0, 1);

        // R5 random thresholds against a bench model
        for (int k = 0; k < 6; k++) begin
            thr = 1 + ($urandom % 5);
            wr(3, thr << 16);
            mcnt = 0;
            for (int i = 0; i < 12; i++) begin
                pulse(1, 0, 0, 0, 0);
                mcnt++;
                rd(0, v);
                if (mcnt >= thr) begin
                    chk("R5 rnd flag", v, 1);
                    mcnt = 0;
                    wr(0, 1);
                end else begin
                    chk("R5 rnd noflag", v, 0);
                end
                rd(3, v); chk("R5 rnd cnt", v, (thr << 16) | mcnt);
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule